// File: doc/BRIEF.md
# Half-Duplex Transmit Collision Retry Controller

This block sequences one transmit frame of a half-duplex Ethernet MAC. The host writes a non-zero two-bit transmit command while the block is idle. The block then latches the frame's start address in the transmit FIFO and drives the FIFO read pointer forward one byte at a time. It also counts how many bytes of the frame have gone out on the wire.

A collision that arrives while that byte count is still below the early-window size is handled locally. The read pointer jumps back to the latched start address, and the block waits for the external backoff timer. It then replays the frame from the FIFO, so nothing is fetched again from packet memory. A collision after the window aborts the frame at once. A collision on the final allowed attempt also aborts the frame, and so does a FIFO underrun.

The block keeps a last-frame status byte that holds the collision count and the error flags. When the frame ends, the block clears the command bits. It also sets either a success bit or an error bit in a sticky interrupt status register. That register drives a masked, registered interrupt request.

Top module: `txretry_ctrl`

## Requirements
- R1: While idle, a command write with non-zero data latches the data into `cmd_o`, clears `stat_o` to 0, loads `rd_ptr_o` with `base_ptr_i` and raises `tx_active_o` on the next edge. A command write while a frame is in progress has no effect, and a write of zero while idle is ignored.
- R2: While sending, each `byte_sent_i` pulse advances `rd_ptr_o` by one, modulo 2^PTR_W.
- R3: A collision while fewer than WINDOW_BYTES bytes have been sent, with a count below 15, does four things. It increments the count, restores `rd_ptr_o` to the frame start, drops `tx_active_o` and raises `backoff_req_o`. Byte pulses are ignored while waiting. `backoff_done_i` resumes sending, and the window count restarts from zero.
- R4: A collision after WINDOW_BYTES or more bytes have been sent aborts the frame with no retry. It sets the late-collision flag (`stat_o` bit 5) and increments the count.
- R5: A collision inside the window when the count already reads 15 aborts the frame as an excessive-collision error. The count stays at 15.
- R6: `underrun_i` while sending aborts the frame and sets `stat_o` bit 4. `crs_lost_i` while sending sets `stat_o` bit 6, and the frame continues.
- R7: `stat_o` layout: bits 3:0 hold the collision count, bit 4 underrun, bit 5 late collision, bit 6 carrier lost. Bit 7 is the OR of bits 4 to 6 and the excessive-collision condition.
- R8: When a frame ends, by `frame_end_i` or by abort, `cmd_o` returns to 0 and `tx_active_o` falls on that edge. On success, `istat_o` bit 2 is set and the count equals the collisions the frame saw.
- R9: A frame that ends with `stat_o` bit 7 set sets `istat_o` bit 4 and not bit 2. The two bits are never set by the same frame.
- R10: The `istat_o` bits are sticky and are cleared by writing 1 on `istat_clr_i`. A new event in the same cycle as its clear leaves the bit set.
- R11: `irq_o` equals, one cycle later, the OR of `istat_o & imask_i`. Bit 2 of the mask enables success and bit 4 enables error.
- R12: In one sending cycle the inputs are served in this order: underrun, then collision, then frame end, then byte sent. Lower-priority inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 2 | Command bits written |
| base_ptr_i | input | PTR_W | FIFO address of the frame's first byte |
| byte_sent_i | input | 1 | One byte left the MAC |
| frame_end_i | input | 1 | Last byte of the frame left the MAC |
| col_i | input | 1 | Collision detected |
| underrun_i | input | 1 | FIFO ran dry mid-frame |
| crs_lost_i | input | 1 | Carrier dropped during transmit |
| backoff_done_i | input | 1 | Backoff interval elapsed |
| istat_clr_i | input | 8 | Write-1-to-clear for interrupt status |
| imask_i | input | 8 | Interrupt enables |
| cmd_o | output | 2 | Command bits, cleared at completion |
| tx_active_o | output | 1 | Frame being sent |
| backoff_req_o | output | 1 | Waiting for backoff to finish |
| rd_ptr_o | output | PTR_W | FIFO read pointer |
| stat_o | output | CC_W+4 | Last-frame status |
| istat_o | output | 8 | Sticky interrupt status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with WINDOW_BYTES of 8 and PTR_W of 6. CC_W stays at its default of 4. With an 8-byte window, a late collision takes only a few byte pulses, which keeps the late-collision path short. The narrow pointer lets a frame start near the top of the address space, so the pointer wrap on both advance and rewind is exercised. Keeping the full 4-bit count means the complete run of sixteen colliding attempts up to the excessive-collision abort is driven for real and checked against the reference model on every cycle.

// File: rtl/txr_pkg.sv
package txr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } txr_state_e;

    localparam int IST_W       = 8;
    localparam int IST_OK_BIT  = 2;
    localparam int IST_ERR_BIT = 4;
endpackage

// File: rtl/txr_window.sv
module txr_window #(
    parameter int WINDOW_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic byte_i,
    output logic in_win_o
);
    localparam int CW = $clog2(WINDOW_BYTES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW_BYTES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = '0;
        else if (byte_i && cnt_q != LIMIT)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign in_win_o = (cnt_q < LIMIT);
endmodule

// File: rtl/txr_irq.sv
module txr_irq
    import txr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ok_i,
    input  logic             err_i,
    input  logic [IST_W-1:0] clr_i,
    input  logic [IST_W-1:0] mask_i,
    output logic [IST_W-1:0] istat_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [IST_W-1:0] ist;
        logic             irq;
    } irq_regs_t;

    irq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = |(r_q.ist & mask_i);
        r_d.ist = r_q.ist & ~clr_i;
        if (ok_i)  r_d.ist[IST_OK_BIT]  = 1'b1;
        if (err_i) r_d.ist[IST_ERR_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign istat_o = r_q.ist;
    assign irq_o   = r_q.irq;
endmodule

// File: rtl/txretry_ctrl.sv
module txretry_ctrl
    import txr_pkg::*;
#(
    parameter int PTR_W        = 8,
    parameter int WINDOW_BYTES = 64,
    parameter int CC_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [1:0]        cmd_wdata_i,
    input  logic [PTR_W-1:0]  base_ptr_i,
    input  logic              byte_sent_i,
    input  logic              frame_end_i,
    input  logic              col_i,
    input  logic              underrun_i,
    input  logic              crs_lost_i,
    input  logic              backoff_done_i,
    input  logic [7:0]        istat_clr_i,
    input  logic [7:0]        imask_i,
    output logic [1:0]        cmd_o,
    output logic              tx_active_o,
    output logic              backoff_req_o,
    output logic [PTR_W-1:0]  rd_ptr_o,
    output logic [CC_W+3:0]   stat_o,
    output logic [7:0]        istat_o,
    output logic              irq_o
);
    localparam logic [CC_W-1:0] CC_MAX = '1;

    typedef struct packed {
        txr_state_e       state;
        logic [1:0]       cmd;
        logic [PTR_W-1:0] base;
        logic [PTR_W-1:0] ptr;
        logic [CC_W-1:0]  cc;
        logic             ufl;
        logic             owc;
        logic             crs;
        logic             exc;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic win_restart, win_byte, in_win;
    logic finish, ev_ok, ev_err, err_d;

    txr_window #(.WINDOW_BYTES(WINDOW_BYTES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (win_restart),
        .byte_i    (win_byte),
        .in_win_o  (in_win)
    );

    always_comb begin
        r_d         = r_q;
        win_restart = 1'b0;
        win_byte    = 1'b0;
        finish      = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_wr_i && cmd_wdata_i != 2'b00) begin
                    r_d.state   = ST_SEND;
                    r_d.cmd     = cmd_wdata_i;
                    r_d.base    = base_ptr_i;
                    r_d.ptr     = base_ptr_i;
                    r_d.cc      = '0;
                    r_d.ufl     = 1'b0;
                    r_d.owc     = 1'b0;
                    r_d.crs     = 1'b0;
                    r_d.exc     = 1'b0;
                    win_restart = 1'b1;
                end
            end
            ST_SEND: begin
                if (crs_lost_i) r_d.crs = 1'b1;
                if (underrun_i) begin
                    r_d.ufl = 1'b1;
                    finish  = 1'b1;
                end else if (col_i) begin
                    if (!in_win) begin
                        r_d.owc = 1'b1;
                        if (r_q.cc != CC_MAX) r_d.cc = r_q.cc + CC_W'(1);
                        finish = 1'b1;
                    end else if (r_q.cc == CC_MAX) begin
                        r_d.exc = 1'b1;
                        finish  = 1'b1;
                    end else begin
                        r_d.cc      = r_q.cc + CC_W'(1);
                        r_d.ptr     = r_q.base;
                        r_d.state   = ST_WAIT;
                        win_restart = 1'b1;
                    end
                end else if (frame_end_i) begin
                    finish = 1'b1;
                end else if (byte_sent_i) begin
                    r_d.ptr  = r_q.ptr + PTR_W'(1);
                    win_byte = 1'b1;
                end
            end
            ST_WAIT: begin
                if (backoff_done_i) r_d.state = ST_SEND;
            end
            default: r_d.state = ST_IDLE;
        endcase
        err_d = r_d.ufl | r_d.owc | r_d.crs | r_d.exc;
        if (finish) begin
            r_d.state = ST_IDLE;
            r_d.cmd   = 2'b00;
        end
        ev_err = finish & err_d;
        ev_ok  = finish & ~err_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    txr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ok_i    (ev_ok),
        .err_i   (ev_err),
        .clr_i   (istat_clr_i),
        .mask_i  (imask_i),
        .istat_o (istat_o),
        .irq_o   (irq_o)
    );

    assign cmd_o         = r_q.cmd;
    assign tx_active_o   = (r_q.state == ST_SEND);
    assign backoff_req_o = (r_q.state == ST_WAIT);
    assign rd_ptr_o      = r_q.ptr;
    assign stat_o        = {(r_q.ufl | r_q.owc | r_q.crs | r_q.exc),
                            r_q.crs, r_q.owc, r_q.ufl, r_q.cc};
endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
    parameter int PTR_W = 8,
    parameter int CC_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] base_i,
    input logic [PTR_W-1:0] rd_ptr_o,
    input logic             tx_active_o,
    input logic             backoff_req_o,
    input logic [1:0]       cmd_o,
    input logic [CC_W+3:0]  stat_o,
    input logic [7:0]       istat_o,
    input logic [7:0]       imask_i,
    input logic             irq_o
);
    localparam int ERRB = CC_W + 3;
    localparam int OWCB = CC_W + 1;

    p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backoff_req_o) |-> (rd_ptr_o == base_i && !tx_active_o));

    p_late_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[OWCB]) |-> (!tx_active_o && !backoff_req_o && cmd_o == 2'b00));

    p_cc_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_active_o || backoff_req_o) && $past(tx_active_o || backoff_req_o))
            |-> (stat_o[CC_W-1:0] >= $past(stat_o[CC_W-1:0])));

    p_ok_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_o[2]) |-> (!stat_o[ERRB] && cmd_o == 2'b00 && !tx_active_o));

    p_err_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_o[4]) |-> (stat_o[ERRB] && cmd_o == 2'b00));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(istat_o[2]) |-> !$rose(istat_o[4]));

    p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(istat_o & imask_i)));
endmodule

bind txretry_ctrl txr_checker #(.PTR_W(PTR_W), .CC_W(CC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_i        (r_q.base),
    .rd_ptr_o      (rd_ptr_o),
    .tx_active_o   (tx_active_o),
    .backoff_req_o (backoff_req_o),
    .cmd_o         (cmd_o),
    .stat_o        (stat_o),
    .istat_o       (istat_o),
    .imask_i       (imask_i),
    .irq_o         (irq_o)
);

// File: tb/sim_txretry_ctrl.sv
`timescale 1ns/1ps
module sim_txretry_ctrl;
    localparam int PTR_W = 6;
    localparam int WIN   = 8;
    localparam int CC_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 0; logic [1:0] cmd_wd = 0; logic [PTR_W-1:0] base = 0;
    logic bs = 0, fe = 0, co = 0, ur = 0, cl = 0, bd = 0;
    logic [7:0] clr = 0, imask = 0;
    logic [1:0] cmd_o; logic tx_act, bo_req; logic [PTR_W-1:0] rd_ptr;
    logic [CC_W+3:0] stat; logic [7:0] istat; logic irq;

    always #4 clk = ~clk;

    txretry_ctrl #(.PTR_W(PTR_W), .WINDOW_BYTES(WIN), .CC_W(CC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wd),
        .base_ptr_i(base), .byte_sent_i(bs), .frame_end_i(fe), .col_i(co),
        .underrun_i(ur), .crs_lost_i(cl), .backoff_done_i(bd),
        .istat_clr_i(clr), .imask_i(imask), .cmd_o(cmd_o), .tx_active_o(tx_act),
        .backoff_req_o(bo_req), .rd_ptr_o(rd_ptr), .stat_o(stat),
        .istat_o(istat), .irq_o(irq));

    // ---------------- behavioural reference model ----------------
    int m_st;              // 0 idle, 1 sending, 2 waiting for backoff
    int m_bytes, m_cc;
    int m_base, m_ptr;
    bit m_ufl, m_owc, m_crs, m_exc, m_irq;
    bit [1:0] m_cmd;
    bit [7:0] m_ist;

    always @(posedge clk or negedge rst_n) begin
        bit done, err;
        bit [7:0] nist;
        if (!rst_n) begin
            m_st = 0; m_bytes = 0; m_cc = 0; m_base = 0; m_ptr = 0;
            m_ufl = 0; m_owc = 0; m_crs = 0; m_exc = 0; m_irq = 0;
            m_cmd = 0; m_ist = 0;
        end else begin
            done  = 0;
            m_irq = (m_ist & imask) != 0;
            nist  = m_ist & ~clr;
            if (m_st == 0) begin
                if (cmd_wr && cmd_wd != 0) begin
                    m_st = 1; m_cmd = cmd_wd; m_base = int'(base); m_ptr = int'(base);
                    m_bytes = 0; m_cc = 0; m_ufl = 0; m_owc = 0; m_crs = 0; m_exc = 0;
                end
            end else if (m_st == 1) begin
                if (cl) m_crs = 1;
                if (ur) begin m_ufl = 1; done = 1; end
                else if (co) begin
                    if (m_bytes >= WIN) begin
                        m_owc = 1; if (m_cc < 15) m_cc++; done = 1;
                    end else if (m_cc == 15) begin
                        m_exc = 1; done = 1;
                    end else begin
                        m_cc++; m_ptr = m_base; m_bytes = 0; m_st = 2;
                    end
                end else if (fe) done = 1;
                else if (bs) begin m_ptr = (m_ptr + 1) % (1 << PTR_W); m_bytes++; end
            end else begin
                if (bd) m_st = 1;
            end
            if (done) begin
                err = m_ufl | m_owc | m_crs | m_exc;
                m_st = 0; m_cmd = 0;
                if (err) nist[4] = 1; else nist[2] = 1;
            end
            m_ist = nist;
        end
    end

    function automatic bit [7:0] m_stat();
        return {(m_ufl | m_owc | m_crs | m_exc), m_crs, m_owc, m_ufl, 4'(m_cc)};
    endfunction

    // per-cycle comparison, own counters
    int cmp_tot = 0, cmp_bad = 0;
    task automatic cmpf(input string tag, input int act, input int exp);
        cmp_tot++;
        if (act != exp) begin
            cmp_bad++;
            $display("FAIL %s model compare at %0t act=%0h exp=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmpf("R1 tx_active", int'(tx_act), int'(m_st == 1));
            cmpf("R3 backoff_req", int'(bo_req), int'(m_st == 2));
            cmpf("R2 rd_ptr", int'(rd_ptr), m_ptr);
            cmpf("R8 cmd", int'(cmd_o), int'(m_cmd));
            cmpf("R7 stat", int'(stat), int'(m_stat()));
            cmpf("R9 istat", int'(istat), int'(m_ist));
            cmpf("R11 irq", int'(irq), int'(m_irq));
        end
    end

    // ---------------- directed scenarios ----------------
    int tot = 0, bad = 0;
    task automatic chk(input string tag, input int act, input int exp);
        tot++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // apply one cycle of inputs at the falling edge
    task automatic cyc(input bit w = 0, input bit [1:0] wd = 0, input bit [PTR_W-1:0] b = 0,
                       input bit ibs = 0, input bit ife = 0, input bit ico = 0,
                       input bit iur = 0, input bit icl = 0, input bit ibd = 0,
                       input bit [7:0] iclr = 0);
        @(negedge clk);
        cmd_wr = w; cmd_wd = wd; base = b; bs = ibs; fe = ife; co = ico;
        ur = iur; cl = icl; bd = ibd; clr = iclr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic run_all();
        idle(1);
        chk("R1 reset cmd", cmd_o, 0);
        chk("R1 reset stat", stat, 0);
        chk("R9 reset istat", istat, 0);
        chk("R11 reset irq", irq, 0);
        imask = 8'h14;

        // zero write ignored, then clean success with pointer wrap
        cyc(1, 2'b00, 6'd3); idle(1);
        chk("R1 zero cmd ignored", tx_act, 0);
        cyc(1, 2'b11, 6'd62); idle(1);
        chk("R1 start active", tx_act, 1);
        chk("R1 start cmd", cmd_o, 3);
        chk("R1 start ptr", rd_ptr, 62);
        cyc(.ibs(1)); cyc(.ibs(1)); cyc(.ibs(1)); idle(1);
        chk("R2 ptr wrap", rd_ptr, 1);
        cyc(1, 2'b01, 6'd20); idle(1);
        chk("R1 busy write ignored ptr", rd_ptr, 1);
        chk("R1 busy write ignored cmd", cmd_o, 3);
        cyc(.ife(1)); idle(1);
        chk("R8 cmd cleared", cmd_o, 0);
        chk("R8 success bit", istat, 8'h04);
        chk("R8 stat clean", stat, 0);
        idle(1);
        chk("R11 irq raised", irq, 1);
        cyc(.iclr(8'h04)); idle(1);
        chk("R10 w1c clears", istat, 0);

        // in-window retries twice, then success
        cyc(1, 2'b10, 6'd10); cyc(.ibs(1)); cyc(.ibs(1)); cyc(.ico(1)); idle(1);
        chk("R3 backoff req", bo_req, 1);
        chk("R3 ptr rewound", rd_ptr, 10);
        chk("R3 count", stat, 1);
        cyc(.ibs(1)); cyc(.ibs(1)); idle(1);
        chk("R3 bytes ignored in backoff", rd_ptr, 10);
        cyc(.ibd(1)); cyc(.ibs(1)); cyc(.ibs(1)); cyc(.ibs(1));
        cyc(.ico(1), .ife(1)); idle(1);
        chk("R12 col beats end", bo_req, 1);
        chk("R3 second rewind", rd_ptr, 10);
        cyc(.ibd(1)); cyc(.ife(1), .ibs(1)); idle(1);
        chk("R12 end beats byte ptr", rd_ptr, 10);
        chk("R8 count on success", stat, 2);
        chk("R9 ok only", istat, 8'h04);
        cyc(.iclr(8'hFF));

        // late collision after window
        cyc(1, 2'b11, 6'd0);
        idle(1);
        chk("R1 stat cleared at start", stat, 0);
        for (int i = 0; i < WIN; i++) cyc(.ibs(1));
        cyc(.ico(1)); idle(1);
        chk("R4 late abort stat", stat, 8'hA1);
        chk("R4 no retry", bo_req, 0);
        chk("R9 error bit only", istat, 8'h10);
        idle(1);
        chk("R11 irq on error", irq, 1);
        cyc(.iclr(8'hFF)); idle(2);
        chk("R11 irq drops", irq, 0);

        // excessive collisions
        cyc(1, 2'b01, 6'd5);
        for (int i = 0; i < 15; i++) begin cyc(.ico(1)); cyc(.ibd(1)); end
        idle(1);
        chk("R5 count at limit still sending", stat, 8'h0F);
        cyc(.ico(1)); idle(1);
        chk("R5 excessive stat", stat, 8'h8F);
        chk("R5 aborted", tx_act, 0);
        chk("R9 excessive error irq", istat, 8'h10);

        // carrier lost continues, underrun beats collision; set wins over clear
        cyc(1, 2'b11, 6'd7); cyc(.ibs(1)); cyc(.icl(1)); idle(1);
        chk("R6 crs flag", stat, 8'hC0);
        chk("R6 still sending", tx_act, 1);
        cyc(.iur(1), .ico(1), .iclr(8'h10)); idle(1);
        chk("R12 underrun over col", stat, 8'hD0);
        chk("R10 set wins over clear", istat, 8'h10);
        cyc(.iclr(8'hFF));

        // masked success: no interrupt
        imask = 8'h00;
        cyc(1, 2'b01, 6'd1); cyc(.ife(1)); idle(3);
        chk("R11 masked irq", irq, 0);
        chk("R8 success no mask effect", istat, 8'h04);
        idle(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                bad++; tot++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", tot + cmp_tot, bad + cmp_bad);
        $finish;
    end
endmodule